// File: doc/BRIEF.md
# ALU Condition Flag Unit

This block turns the outcome of one ALU operation into a set of condition flags and keeps them in a flag register. The ALU supplies both operands, its result, a per-bit carry/borrow vector, the last bit shifted out, an operation class and an operand size. From these the block derives zero, sign, parity, carry, overflow and half-carry (carry out of bit 3 into bit 4, for decimal-adjust support). All of them are computed on the selected operand width: a quarter, a half or all of the datapath width.

A write enable and a six-bit update mask pick which status flags take their new value on the next clock edge. Flags that are not picked keep their stored value. The same register holds three control flags: interrupt enable, string direction and single-step trap. These are never touched by ALU writes. They change only through explicit set and clear commands. The full nine-bit register is visible on one output.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all nine flag bits are cleared to 0 at that edge.
- R2: Zero (bit 3) becomes 1 when the result bits inside the selected size are all zero, and 0 otherwise. Result bits above the selected size have no effect.
- R3: Sign (bit 4) becomes the top bit of the selected size of the result: bit 7, 15 or 31 with the default 32-bit width.
- R4: Parity (bit 1) becomes 1 when the selected size of the result holds an odd number of ones, and 0 when it holds an even number.
- R5: Carry (bit 0) takes `carry_vec` at the top bit of the selected size for add (class 0) and subtract (class 1). For shift/rotate (class 3) it takes `shift_out`.
- R6: Half-carry (bit 2) takes `carry_vec[3]` for add and subtract, and is cleared for logic (class 2) and shift.
- R7: Overflow (bit 5) is set for an add whose operands share a sign that the result lacks. It is set for a subtract whose operands differ in sign and whose result sign differs from operand A. Logic clears both carry and overflow. A shift leaves overflow unchanged.
- R8: A status flag is written at a clock edge only when `wr_en` is 1 and its `upd_mask` bit is 1. The mask bits 0..5 map to carry, parity, half-carry, zero, sign and overflow. In every other case the flag holds its value.
- R9: Control flags (bit 6 interrupt enable, bit 7 direction, bit 8 trap) are set by `ctl_set[i]` and cleared by `ctl_clr[i]`, with clear winning when both are given. They ignore `wr_en`, `upd_mask` and all ALU inputs.
- R10: Size code 0 selects a quarter of the data width, 1 selects half, and 2 or 3 select the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_class | input | 2 | 0 add, 1 subtract, 2 logic, 3 shift/rotate |
| op_size | input | 2 | 0 quarter, 1 half, 2/3 full width |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| alu_res | input | DATA_W | ALU result |
| carry_vec | input | DATA_W | Carry (add) or borrow (subtract) out of each bit |
| shift_out | input | 1 | Last bit shifted out |
| wr_en | input | 1 | Status flag write enable |
| upd_mask | input | 6 | Per-status-flag update select |
| ctl_set | input | 3 | Set commands for control flags |
| ctl_clr | input | 3 | Clear commands for control flags |
| flags | output | 9 | Flag register contents |

## Verification
Adds and subtracts are tried at the signed boundaries 0x7F+1 and 0x80000000-1, so overflow is separated from carry. The wrap 0xFF+1 is tried so that zero, carry and half-carry all rise together. A byte-size result with nonzero upper bits shows that size masking reaches zero, sign and parity. A logic operation after a carry-setting add shows that carry and overflow are cleared, and a shift after an overflowing add shows that overflow is kept. Partial masks, disabled writes and conflicting control commands separate flag selection from computation. A long run of random operands across all classes and sizes is compared against a behavioural model on every clock.

// File: rtl/alu_flag_pkg.sv
// Shared types and flag bit positions for the ALU condition flag unit.
// Assumes: status flags occupy bits 0..5, control flags bits 6..8.
package alu_flag_pkg;
    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_SUB   = 2'd1,
        OPC_LOGIC = 2'd2,
        OPC_SHIFT = 2'd3
    } op_class_e;

    localparam int NUM_STATUS = 6;
    localparam int NUM_CTL    = 3;
    localparam int NUM_FLAGS  = NUM_STATUS + NUM_CTL;

    localparam int FB_CARRY  = 0;
    localparam int FB_PARITY = 1;
    localparam int FB_HALF   = 2;
    localparam int FB_ZERO   = 3;
    localparam int FB_SIGN   = 4;
    localparam int FB_OVF    = 5;
endpackage

// File: rtl/flag_calc.sv
// Combinational derivation of the six status flags from one ALU operation.
// Assumes: carry_vec holds carries for add and borrows for subtract;
// DATA_W is a multiple of 8 and at least 8.
module flag_calc
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]            op_class,
    input  logic [1:0]            op_size,
    input  logic [DATA_W-1:0]     opnd_a,
    input  logic [DATA_W-1:0]     opnd_b,
    input  logic [DATA_W-1:0]     alu_res,
    input  logic [DATA_W-1:0]     carry_vec,
    input  logic                  shift_out,
    input  logic                  cur_ovf,
    output logic [NUM_STATUS-1:0] next_status
);
    localparam int QW = DATA_W / 4;
    localparam int HW = DATA_W / 2;

    logic [DATA_W-1:0] size_mask;
    logic              a_top, b_top, r_top, c_top;
    logic [DATA_W-1:0] sized_res;
    op_class_e         opc;

    assign opc = op_class_e'(op_class);

    // Pick width mask and top bits of the selected operand size.
    always_comb begin
        case (op_size)
            2'd0: begin
                size_mask = {{(DATA_W-QW){1'b0}}, {QW{1'b1}}};
                a_top = opnd_a[QW-1];
                b_top = opnd_b[QW-1];
                r_top = alu_res[QW-1];
                c_top = carry_vec[QW-1];
            end
            2'd1: begin
                size_mask = {{(DATA_W-HW){1'b0}}, {HW{1'b1}}};
                a_top = opnd_a[HW-1];
                b_top = opnd_b[HW-1];
                r_top = alu_res[HW-1];
                c_top = carry_vec[HW-1];
            end
            default: begin
                size_mask = {DATA_W{1'b1}};
                a_top = opnd_a[DATA_W-1];
                b_top = opnd_b[DATA_W-1];
                r_top = alu_res[DATA_W-1];
                c_top = carry_vec[DATA_W-1];
            end
        endcase
    end

    assign sized_res = alu_res & size_mask;

    // Build the new status flag vector per operation class.
    always_comb begin
        next_status            = '0;
        next_status[FB_ZERO]   = ~|sized_res;
        next_status[FB_PARITY] = ^sized_res;
        next_status[FB_SIGN]   = r_top;
        case (opc)
            OPC_ADD: begin
                next_status[FB_CARRY] = c_top;
                next_status[FB_HALF]  = carry_vec[3];
                next_status[FB_OVF]   = (a_top == b_top) && (r_top != a_top);
            end
            OPC_SUB: begin
                next_status[FB_CARRY] = c_top;
                next_status[FB_HALF]  = carry_vec[3];
                next_status[FB_OVF]   = (a_top != b_top) && (r_top != a_top);
            end
            OPC_LOGIC: begin
                next_status[FB_CARRY] = 1'b0;
                next_status[FB_HALF]  = 1'b0;
                next_status[FB_OVF]   = 1'b0;
            end
            default: begin
                next_status[FB_CARRY] = shift_out;
                next_status[FB_HALF]  = 1'b0;
                next_status[FB_OVF]   = cur_ovf;
            end
        endcase
    end
endmodule

// File: rtl/flag_status_reg.sv
// Status flag storage with a global write enable and a per-flag mask.
// Assumes: synchronous active-low reset clears every flag.
module flag_status_reg
    import alu_flag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [NUM_STATUS-1:0] upd_mask,
    input  logic [NUM_STATUS-1:0] next_status,
    output logic [NUM_STATUS-1:0] status_q
);
    for (genvar i = 0; i < NUM_STATUS; i++) begin : g_bit
        // Load one flag when enabled and selected, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_q[i] <= 1'b0;
            else if (wr_en && upd_mask[i])
                status_q[i] <= next_status[i];
        end
    end

    // R8: with writes disabled the status flags do not move
    p_hold_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status_q));

    // R8: unselected flags do not move even when writing
    p_hold_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && upd_mask == '0) |=> $stable(status_q));
endmodule

// File: rtl/flag_ctl_reg.sv
// Control flags changed only by explicit set and clear commands.
// Assumes: clear wins over set on the same bit in the same cycle.
module flag_ctl_reg
    import alu_flag_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTL-1:0] ctl_set,
    input  logic [NUM_CTL-1:0] ctl_clr,
    output logic [NUM_CTL-1:0] ctl_q
);
    for (genvar i = 0; i < NUM_CTL; i++) begin : g_bit
        // Apply clear, then set, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctl_q[i] <= 1'b0;
            else if (ctl_clr[i])
                ctl_q[i] <= 1'b0;
            else if (ctl_set[i])
                ctl_q[i] <= 1'b1;
        end
    end

    // R9: without commands the control flags keep their value
    p_ctl_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == '0 && ctl_clr == '0) |=> $stable(ctl_q));

    // R9: a clear command always leaves the flag at 0
    p_ctl_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clr[0] |=> !ctl_q[0]);
endmodule

// File: rtl/alu_flag_unit.sv
// Top of the ALU condition flag unit: flag derivation plus flag register.
// Assumes: inputs are stable around the rising clock edge.
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           op_class,
    input  logic [1:0]           op_size,
    input  logic [DATA_W-1:0]    opnd_a,
    input  logic [DATA_W-1:0]    opnd_b,
    input  logic [DATA_W-1:0]    alu_res,
    input  logic [DATA_W-1:0]    carry_vec,
    input  logic                 shift_out,
    input  logic                 wr_en,
    input  logic [5:0]           upd_mask,
    input  logic [2:0]           ctl_set,
    input  logic [2:0]           ctl_clr,
    output logic [8:0]           flags
);
    logic [NUM_STATUS-1:0] next_status;
    logic [NUM_STATUS-1:0] status_q;
    logic [NUM_CTL-1:0]    ctl_q;

    flag_calc #(.DATA_W(DATA_W)) u_calc (
        .op_class    (op_class),
        .op_size     (op_size),
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .alu_res     (alu_res),
        .carry_vec   (carry_vec),
        .shift_out   (shift_out),
        .cur_ovf     (status_q[FB_OVF]),
        .next_status (next_status)
    );

    flag_status_reg u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .upd_mask    (upd_mask),
        .next_status (next_status),
        .status_q    (status_q)
    );

    flag_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_set (ctl_set),
        .ctl_clr (ctl_clr),
        .ctl_q   (ctl_q)
    );

    assign flags = {ctl_q, status_q};

    // R7: a logic write leaves carry and overflow cleared
    p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_class == 2'd2 && upd_mask[FB_CARRY] && upd_mask[FB_OVF])
        |=> (!flags[FB_CARRY] && !flags[FB_OVF]));

    // R7: a shift never changes overflow
    p_shift_keeps_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_class == 2'd3) |=> $stable(flags[FB_OVF]));

    // R2 R3: zero and sign cannot both be set after one write of both
    p_zero_sign_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && upd_mask[FB_ZERO] && upd_mask[FB_SIGN])
        |=> !(flags[FB_ZERO] && flags[FB_SIGN]));

    // R4: a zero result always has even parity
    p_zero_even_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && upd_mask[FB_ZERO] && upd_mask[FB_PARITY])
        |=> !(flags[FB_ZERO] && flags[FB_PARITY]));

    // R9: status writes never reach control flags
    p_ctl_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == '0 && ctl_clr == '0) |=> $stable(flags[8:6]));
endmodule

// File: tb/alu_flag_unit_tb.sv
// Self-checking bench: behavioural flag model compared every clock.
module alu_flag_unit_tb_top;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    op_class, op_size;
    logic [W-1:0]  opnd_a, opnd_b, alu_res, carry_vec;
    logic          shift_out, wr_en;
    logic [5:0]    upd_mask;
    logic [2:0]    ctl_set, ctl_clr;
    logic [8:0]    flags;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_flags = '0;

    always #10 clk = ~clk;

    alu_flag_unit #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .op_size(op_size),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res),
        .carry_vec(carry_vec), .shift_out(shift_out), .wr_en(wr_en),
        .upd_mask(upd_mask), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
        .flags(flags)
    );

    task automatic check(input string tag);
        checks++;
        if (flags !== exp_flags) begin
            errors++;
            $display("FAIL %s: flags actual=%b expected=%b", tag, flags, exp_flags);
        end
    endtask

    function automatic int top_of(input logic [1:0] sz);
        case (sz)
            2'd0: return 7;
            2'd1: return 15;
            default: return 31;
        endcase
    endfunction

    // Reference model for one clock edge
    task automatic model_edge();
        int t;
        int ones;
        logic [8:0] n;
        n = exp_flags;
        if (!rst_n) begin
            exp_flags = '0;
            return;
        end
        if (wr_en) begin
            t = top_of(op_size);
            ones = 0;
            for (int i = 0; i <= t; i++) ones += alu_res[i];
            if (upd_mask[3]) n[3] = (ones == 0);
            if (upd_mask[1]) n[1] = (ones % 2 == 1);
            if (upd_mask[4]) n[4] = alu_res[t];
            if (op_class <= 2'd1) begin
                if (upd_mask[0]) n[0] = carry_vec[t];
                if (upd_mask[2]) n[2] = carry_vec[3];
                if (upd_mask[5]) begin
                    if (op_class == 2'd0)
                        n[5] = (opnd_a[t] == opnd_b[t]) && (alu_res[t] != opnd_a[t]);
                    else
                        n[5] = (opnd_a[t] != opnd_b[t]) && (alu_res[t] != opnd_a[t]);
                end
            end else if (op_class == 2'd2) begin
                if (upd_mask[0]) n[0] = 1'b0;
                if (upd_mask[2]) n[2] = 1'b0;
                if (upd_mask[5]) n[5] = 1'b0;
            end else begin
                if (upd_mask[0]) n[0] = shift_out;
                if (upd_mask[2]) n[2] = 1'b0;
            end
        end
        for (int i = 0; i < 3; i++) begin
            if (ctl_clr[i]) n[6+i] = 1'b0;
            else if (ctl_set[i]) n[6+i] = 1'b1;
        end
        exp_flags = n;
    endtask

    task automatic gen_add(input logic [W-1:0] a, input logic [W-1:0] b,
                           output logic [W-1:0] r, output logic [W-1:0] cv);
        logic c = 1'b0;
        for (int i = 0; i < W; i++) begin
            r[i]  = a[i] ^ b[i] ^ c;
            cv[i] = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
            c = cv[i];
        end
    endtask

    task automatic gen_sub(input logic [W-1:0] a, input logic [W-1:0] b,
                           output logic [W-1:0] r, output logic [W-1:0] cv);
        logic bw = 1'b0;
        for (int i = 0; i < W; i++) begin
            r[i]  = a[i] ^ b[i] ^ bw;
            cv[i] = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & bw);
            bw = cv[i];
        end
    endtask

    // Drive one operation, clock it, then compare away from the edge
    task automatic run(input logic [1:0] opc, input logic [1:0] sz,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic we, input logic [5:0] msk,
                       input logic [2:0] st, input logic [2:0] cl,
                       input string tag);
        logic [W-1:0] r, cv;
        cv = '0;
        case (opc)
            2'd0: gen_add(a, b, r, cv);
            2'd1: gen_sub(a, b, r, cv);
            2'd2: r = a & b;
            default: r = a << 1;
        endcase
        op_class = opc; op_size = sz; opnd_a = a; opnd_b = b;
        alu_res = r; carry_vec = cv; shift_out = a[top_of(sz)];
        wr_en = we; upd_mask = msk; ctl_set = st; ctl_clr = cl;
        @(posedge clk);
        model_edge();
        #5;
        check(tag);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        op_class = '0; op_size = '0; opnd_a = '0; opnd_b = '0;
        alu_res = '1; carry_vec = '1; shift_out = 1'b1; wr_en = 1'b1;
        upd_mask = '1; ctl_set = '1; ctl_clr = '0;
        repeat (3) @(posedge clk);
        model_edge();
        #5 check("R1 reset");
        rst_n = 1'b1;

        run(2'd0, 2'd0, 32'h7F, 32'h01, 1, 6'h3F, 0, 0, "R7 add8 overflow R4 R6");
        run(2'd0, 2'd0, 32'hFF, 32'h01, 1, 6'h3F, 0, 0, "R2 add8 wrap R5 R6");
        run(2'd0, 2'd0, 32'h1200, 32'h0, 1, 6'h3F, 0, 0, "R2 upper bits ignored R10");
        run(2'd0, 2'd1, 32'h00008000, 32'h0, 1, 6'h3F, 0, 0, "R3 sign bit15");
        run(2'd1, 2'd2, 32'h80000000, 32'h1, 1, 6'h3F, 0, 0, "R7 sub32 overflow");
        run(2'd1, 2'd0, 32'h00, 32'h01, 1, 6'h3F, 0, 0, "R5 sub8 borrow");
        run(2'd2, 2'd2, 32'hF0F0F0F1, 32'hFFFFFFFF, 1, 6'h3F, 0, 0, "R7 logic clears R4");
        run(2'd0, 2'd0, 32'h7F, 32'h01, 1, 6'h3F, 0, 0, "R7 set ovf");
        run(2'd3, 2'd0, 32'h81, 32'h0, 1, 6'h3F, 0, 0, "R5 shift carry R7 ovf kept R6");
        run(2'd0, 2'd0, 32'hFF, 32'h01, 1, 6'b001000, 0, 0, "R8 zero only");
        run(2'd1, 2'd3, 32'h0, 32'h1, 0, 6'h3F, 0, 0, "R8 write disabled");
        run(2'd1, 2'd3, 32'h0, 32'h1, 1, 6'h3F, 0, 0, "R10 size3 full");
        run(2'd0, 2'd2, 32'h0, 32'h0, 0, 6'h00, 3'b111, 0, "R9 set all");
        run(2'd0, 2'd2, 32'h0, 32'h0, 1, 6'h3F, 0, 0, "R9 ALU write leaves ctl");
        run(2'd0, 2'd2, 32'h0, 32'h0, 0, 6'h00, 3'b011, 3'b001, "R9 clear wins");
        run(2'd0, 2'd2, 32'h0, 32'h0, 0, 6'h00, 0, 3'b110, "R9 clear");

        for (int k = 0; k < 400; k++) begin
            run(2'($urandom), 2'($urandom), $urandom, $urandom, 1'($urandom),
                6'($urandom), 3'($urandom), 3'($urandom), "R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule